// File: doc/BRIEF.md
# Segmented Address Translation Unit

The unit turns a segment register value and a 32-bit offset into a physical address. It runs in one of three modes. In real mode the segment value is shifted left by four bits and added to the low half of the offset. In protected mode the segment value is a selector into a small descriptor table held inside the block, and the descriptor's base is added to the offset. In flat mode the same selector lookup and privilege check take place, but the base is taken as zero.

The table is loaded through a write port. A window register picks which part of the table the selectors may reach. A request is accepted through a valid/ready handshake. The block serves one request at a time. The result appears two clock edges after acceptance and is held until the consumer takes it. Each result carries a fault flag. A faulting result always has a zero address.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset the unit is in real mode and the table window holds a start entry of 0 and an entry count of 0. No response is valid and `req_ready_o` is high.
- R2: In real mode the address is `(seg << 4) + off[15:0]`, truncated to 20 bits, so it wraps at 1 MiB. Bits 31:20 are zero, `off[31:16]` is ignored, and the result never faults.
- R3: In protected mode a non-faulting address is the descriptor base plus the 32-bit offset, modulo 2^32.
- R4: In flat mode the selector is checked exactly as in protected mode. A non-faulting address equals the offset, whatever base the descriptor holds.
- R5: Selector fields are: index in bits 15:3, table indicator in bit 2, RPL in bits 1:0. A table indicator of 1 raises a fault. An index of 0 (null selector) raises a fault.
- R6: The table entry used is the window start plus the selector index. A fault is raised when the index is not below the window count, or when the sum reaches 16 or more.
- R7: A descriptor holds its base in bits 31:0 and its DPL in bits 33:32. The CPL is `cs_sel_i[1:0]`, sampled when the request is accepted. A fault is raised when DPL < CPL or DPL < RPL.
- R8: An accepted request gives `resp_valid_o` high after the second rising edge that follows acceptance. `req_ready_o` is low from acceptance until the response is taken.
- R9: While `resp_valid_o` is high and `resp_ready_i` is low, the address and the fault flag hold steady. A faulting response has an address of zero.
- R10: A table write takes effect for requests accepted on later edges.
- R11: Mode encoding is 0 for real, 1 for protected and 2 for flat. A mode load with value 3 is ignored, and the previous mode stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_we_i | input | 1 | Load the mode register |
| mode_i | input | 2 | New mode: 0 real, 1 protected, 2 flat |
| tbase_we_i | input | 1 | Load the table window register |
| tbase_i | input | 4 | Window start entry |
| tcount_i | input | 5 | Window entry count |
| tw_en_i | input | 1 | Table write enable |
| tw_idx_i | input | 4 | Table entry to write |
| tw_data_i | input | 64 | Descriptor to write |
| cs_sel_i | input | 16 | Code-segment selector (low two bits are the CPL) |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_seg_i | input | 16 | Segment value or selector |
| req_off_i | input | 32 | Offset |
| resp_valid_o | output | 1 | Result valid |
| resp_ready_i | input | 1 | Consumer takes the result |
| resp_addr_o | output | 32 | Physical address (zero on fault) |
| resp_fault_o | output | 1 | Translation refused |

## Verification
Several rules are checked by assertions on every cycle. These are the handshake timing and exclusivity, result stability under back-pressure, a zero address on any fault, a clean unfaulted 20-bit result in real mode, an address equal to the offset in flat mode, and a forced fault for null selectors. Some behaviour can only be shown by the bench's scenarios against its reference model. This covers the arithmetic for descriptor base plus offset, including wrap-around. It also covers the window offset and its bounds, the DPL comparison against CPL and RPL, when table writes take effect, and an ignored reserved mode load.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_FLAT = 2'd2,
    MODE_RSVD = 2'd3
  } xmode_e;

  localparam int SEG_W   = 16;
  localparam int OFF_W   = 32;
  localparam int DESC_W  = 64;
  localparam int IDX_LSB = 3;
  localparam int IDX_W   = SEG_W - IDX_LSB;
  localparam int TI_BIT  = 2;

  // 20-bit real-mode sum, wrapping at 1 MiB
  function automatic logic [OFF_W-1:0] real_addr(input logic [SEG_W-1:0] seg,
                                                 input logic [OFF_W-1:0] off);
    logic [19:0] s;
    s = {seg, 4'h0} + {4'h0, off[15:0]};
    return {12'h000, s};
  endfunction

  // target segment may not be more privileged than CPL or RPL
  function automatic logic priv_ok(input logic [1:0] dpl, input logic [1:0] cpl,
                                   input logic [1:0] rpl);
    return (dpl >= cpl) && (dpl >= rpl);
  endfunction

  function automatic logic [31:0] desc_base(input logic [DESC_W-1:0] d);
    return d[31:0];
  endfunction

  function automatic logic [1:0] desc_dpl(input logic [DESC_W-1:0] d);
    return d[33:32];
  endfunction
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int AW = 4,
  parameter int DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (!rst_ni)                          ent_q[g] <= '0;
      else if (we_i && widx_i == AW'(g))    ent_q[g] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[ridx_i];
endmodule

// File: rtl/seg_sel_front.sv
module seg_sel_front
  import seg_xlate_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [SEG_W-1:0] sel_i,
  input  logic [AW-1:0]    wstart_i,
  input  logic [AW:0]      wcount_i,
  output logic [AW-1:0]    entry_o,
  output logic             sel_bad_o
);
  localparam int DEPTH = 1 << AW;
  localparam int SUM_W = IDX_W + 1;

  logic [IDX_W-1:0] idx;
  logic [SUM_W-1:0] sum;
  logic             ti_set, is_null, over_cnt, over_tbl;

  always_comb begin
    idx      = sel_i[SEG_W-1:IDX_LSB];
    sum      = {1'b0, idx} + SUM_W'(wstart_i);
    ti_set   = sel_i[TI_BIT];
    is_null  = (idx == '0);
    over_cnt = (SUM_W'(idx) >= SUM_W'(wcount_i));
    over_tbl = (sum >= SUM_W'(DEPTH));
  end

  assign entry_o   = sum[AW-1:0];
  assign sel_bad_o = ti_set | is_null | over_cnt | over_tbl;
endmodule

// File: rtl/seg_addr_back.sv
module seg_addr_back
  import seg_xlate_pkg::*;
(
  input  xmode_e           mode_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       cpl_i,
  input  logic [31:0]      base_i,
  input  logic [1:0]       dpl_i,
  input  logic             sel_bad_i,
  output logic [OFF_W-1:0] addr_o,
  output logic             fault_o
);
  logic             deny;
  logic [OFF_W-1:0] raw;

  always_comb begin
    deny = 1'b0;
    raw  = '0;
    unique case (mode_i)
      MODE_REAL: raw = real_addr(seg_i, off_i);
      MODE_PROT: begin
        deny = sel_bad_i | !priv_ok(dpl_i, cpl_i, seg_i[1:0]);
        raw  = base_i + off_i;
      end
      default: begin
        deny = sel_bad_i | !priv_ok(dpl_i, cpl_i, seg_i[1:0]);
        raw  = off_i;
      end
    endcase
  end

  assign fault_o = deny;
  assign addr_o  = deny ? '0 : raw;
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int TBL_AW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_we_i,
  input  logic [1:0]  mode_i,
  input  logic        tbase_we_i,
  input  logic [3:0]  tbase_i,
  input  logic [4:0]  tcount_i,
  input  logic        tw_en_i,
  input  logic [3:0]  tw_idx_i,
  input  logic [63:0] tw_data_i,
  input  logic [15:0] cs_sel_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [15:0] req_seg_i,
  input  logic [31:0] req_off_i,
  output logic        resp_valid_o,
  input  logic        resp_ready_i,
  output logic [31:0] resp_addr_o,
  output logic        resp_fault_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_RESP} st_e;

  st_e              st_q;
  xmode_e           mode_q, s1_mode_q, rsp_mode_q;
  logic [TBL_AW-1:0] wstart_q;
  logic [TBL_AW:0]   wcount_q;

  logic [SEG_W-1:0] s1_seg_q;
  logic [OFF_W-1:0] s1_off_q;
  logic [1:0]       s1_cpl_q, s1_dpl_q;
  logic [31:0]      s1_base_q;
  logic             s1_bad_q;

  logic [OFF_W-1:0] rsp_addr_q;
  logic             rsp_fault_q;

  // named events
  logic acc_fire, rsp_fire;
  assign acc_fire = req_valid_i && req_ready_o;
  assign rsp_fire = resp_valid_o && resp_ready_i;

  logic [TBL_AW-1:0] entry_w;
  logic              sel_bad_w;
  logic [DESC_W-1:0] desc_w;
  logic [OFF_W-1:0]  calc_addr_w;
  logic              calc_fault_w;
  logic              unused_bits;

  assign unused_bits = ^{desc_w[DESC_W-1:34], cs_sel_i[15:2]};

  seg_desc_table #(.AW(TBL_AW), .DW(DESC_W)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tw_en_i),
    .widx_i  (TBL_AW'(tw_idx_i)),
    .wdata_i (tw_data_i),
    .ridx_i  (entry_w),
    .rdata_o (desc_w)
  );

  seg_sel_front #(.AW(TBL_AW)) u_front (
    .sel_i     (req_seg_i),
    .wstart_i  (wstart_q),
    .wcount_i  (wcount_q),
    .entry_o   (entry_w),
    .sel_bad_o (sel_bad_w)
  );

  seg_addr_back u_back (
    .mode_i    (s1_mode_q),
    .seg_i     (s1_seg_q),
    .off_i     (s1_off_q),
    .cpl_i     (s1_cpl_q),
    .base_i    (s1_base_q),
    .dpl_i     (s1_dpl_q),
    .sel_bad_i (s1_bad_q),
    .addr_o    (calc_addr_w),
    .fault_o   (calc_fault_w)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      mode_q      <= MODE_REAL;
      wstart_q    <= '0;
      wcount_q    <= '0;
      s1_mode_q   <= MODE_REAL;
      s1_seg_q    <= '0;
      s1_off_q    <= '0;
      s1_cpl_q    <= '0;
      s1_dpl_q    <= '0;
      s1_base_q   <= '0;
      s1_bad_q    <= 1'b0;
      rsp_mode_q  <= MODE_REAL;
      rsp_addr_q  <= '0;
      rsp_fault_q <= 1'b0;
    end else begin
      if (mode_we_i && mode_i != MODE_RSVD) mode_q <= xmode_e'(mode_i);
      if (tbase_we_i) begin
        wstart_q <= TBL_AW'(tbase_i);
        wcount_q <= (TBL_AW+1)'(tcount_i);
      end
      unique case (st_q)
        ST_IDLE: if (acc_fire) begin
          s1_mode_q <= mode_q;
          s1_seg_q  <= req_seg_i;
          s1_off_q  <= req_off_i;
          s1_cpl_q  <= cs_sel_i[1:0];
          s1_base_q <= desc_base(desc_w);
          s1_dpl_q  <= desc_dpl(desc_w);
          s1_bad_q  <= sel_bad_w;
          st_q      <= ST_CALC;
        end
        ST_CALC: begin
          rsp_mode_q  <= s1_mode_q;
          rsp_addr_q  <= calc_addr_w;
          rsp_fault_q <= calc_fault_w;
          st_q        <= ST_RESP;
        end
        default: if (rsp_fire) st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign resp_valid_o = (st_q == ST_RESP);
  assign resp_addr_o  = rsp_addr_q;
  assign resp_fault_o = rsp_fault_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        resp_valid_o,
  input logic        resp_ready_i,
  input logic [31:0] resp_addr_o,
  input logic        resp_fault_o,
  input logic [1:0]  rsp_mode,
  input logic [15:0] cap_seg,
  input logic [31:0] cap_off
);
  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !resp_valid_o ##1 resp_valid_o);

  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !req_ready_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_ready_i) |=>
      (resp_valid_o && $stable(resp_addr_o) && $stable(resp_fault_o)));

  p_fault_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_fault_o) |-> (resp_addr_o == 32'h0));

  p_real_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && rsp_mode == MODE_REAL) |->
      (!resp_fault_o && resp_addr_o[31:20] == 12'h0));

  p_flat_offset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && rsp_mode == MODE_FLAT && !resp_fault_o) |->
      (resp_addr_o == cap_off));

  p_null_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && rsp_mode != MODE_REAL && cap_seg[15:3] == 13'h0) |->
      resp_fault_o);
endmodule

bind seg_xlate_unit seg_xlate_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .resp_valid_o (resp_valid_o),
  .resp_ready_i (resp_ready_i),
  .resp_addr_o  (resp_addr_o),
  .resp_fault_o (resp_fault_o),
  .rsp_mode     (rsp_mode_q),
  .cap_seg      (s1_seg_q),
  .cap_off      (s1_off_q)
);

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 0, tbase_we = 0, tw_en = 0, req_valid = 0, resp_ready = 0;
  logic [1:0]  mode = 0;
  logic [3:0]  tbase = 0, tw_idx = 0;
  logic [4:0]  tcount = 0;
  logic [63:0] tw_data = 0;
  logic [15:0] cs_sel = 0, req_seg = 0;
  logic [31:0] req_off = 0;
  logic        req_ready, resp_valid, resp_fault;
  logic [31:0] resp_addr;

  int n_checks = 0, n_errors = 0;

  always #5 clk = ~clk;

  seg_xlate_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_i(mode),
    .tbase_we_i(tbase_we), .tbase_i(tbase), .tcount_i(tcount),
    .tw_en_i(tw_en), .tw_idx_i(tw_idx), .tw_data_i(tw_data),
    .cs_sel_i(cs_sel), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_seg_i(req_seg), .req_off_i(req_off), .resp_valid_o(resp_valid),
    .resp_ready_i(resp_ready), .resp_addr_o(resp_addr), .resp_fault_o(resp_fault)
  );

  // reference state
  int          m_mode = 0, m_base = 0, m_cnt = 0;
  logic [63:0] m_tbl [16];
  int          m_phase = 0;   // 0 idle, 1 computing, 2 holding result

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // handshake model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) m_phase <= 0;
    else if (m_phase == 0 && req_valid) m_phase <= 1;
    else if (m_phase == 1) m_phase <= 2;
    else if (m_phase == 2 && resp_ready) m_phase <= 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (m_phase == 0), "R8 ready", 64'(req_ready), 64'(m_phase == 0));
      chk(resp_valid == (m_phase == 2), "R8 valid", 64'(resp_valid), 64'(m_phase == 2));
    end
  end

  function automatic void ref_x(input logic [15:0] seg, input logic [31:0] off,
                                output logic [31:0] a, output logic f);
    int idx, ent, cpl, rpl, dpl;
    longint sum;
    f = 0;
    a = 0;
    if (m_mode == 0) begin
      a = ((32'(seg) * 16) + 32'(off & 32'hFFFF)) % 32'h100000;
      return;
    end
    idx = int'(seg) / 8;
    rpl = int'(seg) % 4;
    cpl = int'(cs_sel) % 4;
    ent = m_base + idx;
    if (seg[2] || idx == 0 || idx >= m_cnt || ent >= 16) f = 1;
    else begin
      dpl = int'(m_tbl[ent][33:32]);
      if (dpl < cpl || dpl < rpl) f = 1;
      else if (m_mode == 1) begin
        sum = longint'(m_tbl[ent][31:0]) + longint'(off);
        a = sum[31:0];
      end else a = off;
    end
  endfunction

  task automatic xlate(input logic [15:0] seg, input logic [31:0] off,
                       input int stall, input string tag);
    logic [31:0] ea;
    logic ef;
    ref_x(seg, off, ea, ef);
    @(negedge clk);
    req_valid = 1; req_seg = seg; req_off = off;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    chk(resp_valid, {tag, " valid"}, 64'(resp_valid), 64'd1);
    chk(resp_addr == ea, {tag, " addr"}, 64'(resp_addr), 64'(ea));
    chk(resp_fault == ef, {tag, " fault"}, 64'(resp_fault), 64'(ef));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(resp_addr == ea && resp_fault == ef, {tag, " R9 hold"}, 64'(resp_addr), 64'(ea));
    end
    resp_ready = 1;
    @(negedge clk);
    resp_ready = 0;
  endtask

  task automatic wr_desc(input int e, input logic [31:0] base, input logic [1:0] dpl);
    @(negedge clk);
    tw_en = 1; tw_idx = 4'(e); tw_data = {30'h2AAA_5555, dpl, base};
    @(negedge clk);
    tw_en = 0;
    m_tbl[e] = {30'h2AAA_5555, dpl, base};
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_we = 1; mode = m;
    @(negedge clk);
    mode_we = 0;
    if (m != 2'd3) m_mode = int'(m);
  endtask

  task automatic set_win(input int st, input int cnt);
    @(negedge clk);
    tbase_we = 1; tbase = 4'(st); tcount = 5'(cnt);
    @(negedge clk);
    tbase_we = 0;
    m_base = st; m_cnt = cnt;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !resp_valid, "R1 reset handshake", {req_ready, resp_valid}, 64'b10);
    xlate(16'h1234, 32'h0000_0005, 0, "R1 real at reset");
    xlate(16'hFFFF, 32'hABCD_0010, 0, "R2 wrap");
    xlate(16'hB800, 32'h7777_FFFF, 0, "R2 high off ignored");
    set_mode(2'd1);
    cs_sel = 16'h0008;
    xlate(16'h0008, 32'h10, 0, "R1 empty window");
    wr_desc(1, 32'h1000_0000, 2'd0);
    wr_desc(2, 32'h0040_0000, 2'd3);
    wr_desc(3, 32'hFFFF_FF00, 2'd3);
    wr_desc(7, 32'h0000_7000, 2'd2);
    set_win(0, 8);
    xlate(16'h0010, 32'h0000_0100, 0, "R3 base add");
    xlate(16'h0018, 32'h0000_0200, 2, "R3 wrap");
    xlate(16'h000B, 32'h4, 0, "R7 rpl deny");
    xlate(16'h0038, 32'h4, 0, "R7 dpl2 cpl0 ok");
    cs_sel = 16'h0013;
    xlate(16'h0008, 32'h4, 0, "R7 cpl deny");
    xlate(16'h0013, 32'h4, 0, "R7 cpl3 ok");
    cs_sel = 16'h0008;
    xlate(16'h0014, 32'h4, 0, "R5 ti");
    xlate(16'h0000, 32'h4, 0, "R5 null");
    xlate(16'h0003, 32'h4, 0, "R5 null rpl");
    xlate(16'h0040, 32'h4, 0, "R6 count edge");
    xlate(16'h0038, 32'h8, 0, "R6 last in window");
    wr_desc(5, 32'h0005_0000, 2'd0);
    wr_desc(15, 32'h00F0_0000, 2'd1);
    set_win(4, 13);
    xlate(16'h0008, 32'h1, 0, "R6 offset window");
    xlate(16'h0058, 32'h2, 0, "R6 top entry");
    xlate(16'h0060, 32'h3, 0, "R6 past table");
    wr_desc(5, 32'h0123_0000, 2'd0);
    xlate(16'h0008, 32'h1, 0, "R10 rewrite");
    set_mode(2'd3);
    xlate(16'h0008, 32'h1, 0, "R11 reserved ignored");
    set_mode(2'd2);
    xlate(16'h0008, 32'hDEAD_BEEF, 3, "R4 flat");
    xlate(16'h000B, 32'h5, 0, "R4 flat priv");
    xlate(16'h0000, 32'h5, 0, "R4 flat null");
    set_mode(2'd0);
    xlate(16'h0001, 32'h0000_0002, 0, "R11 back to real");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule